// File: doc/BRIEF.md
# Extended Mode Register with DLL Lock Guard

This block models the extended configuration register of a double-data-rate SDRAM device and polices the command timing that follows from it. Each cycle it receives a single command code together with the bank-select and row-address buses. It also receives a flag from the controller saying that all banks are idle. It decodes writes to the extended register and keeps the DLL state and the output drive-strength choice. It also follows self-refresh entry and exit. The block runs a lock counter whenever the DLL turns on.

Its outputs are the effective DLL state, the drive-strength selection, and two permit flags. One flag says whether a read may be issued in the current cycle. The other says the same for a write. One-cycle error pulses report register loads that break the loading rules. Other one-cycle pulses report reads or writes issued while they are not permitted. All of these pins are plain control and status pins. There is no data stream, so no valid/ready handshake is involved.

Top module: `emr_guard`

## Requirements
- R1: A synchronous active-high reset gives the following state: `dll_enabled`=1, `drive_weak`=0, `read_ok`=0, `write_ok`=1, and `load_err`=`timing_err`=0. After reset is released, `read_ok` stays low for the first 200 cycles.
- R2: A legal load is `cmd`=3'd1 (MRS) with `ba`=2'b01, `addr[12:2]`=0, `banks_idle`=1, outside self refresh. From the next cycle, `dll_enabled` equals the inverse of `addr[0]` (0 = on) and `drive_weak` equals `addr[1]` (1 = weak).
- R3: An MRS command with `ba` other than 2'b01 changes no output and raises no error.
- R4: An MRS with `ba`=2'b01 is illegal if any of the following holds: `addr[12:2]` is nonzero, `banks_idle`=0, or the device is in self refresh. An illegal load raises `load_err` for exactly one cycle and leaves `dll_enabled` and `drive_weak` unchanged.
- R5: When a load turns the DLL from off to on, `read_ok` stays low for exactly 200 cycles and then rises. `write_ok` stays high during this time.
- R6: While the DLL is off, `read_ok` is low, and a read (`cmd`=3'd2) raises `timing_err`.
- R7: Self-refresh entry (`cmd`=3'd4) turns `dll_enabled` off from the next cycle. `read_ok` and `write_ok` then stay low until exit.
- R8: Self-refresh exit (`cmd`=3'd5) turns `dll_enabled` back on from the next cycle. `read_ok` and `write_ok` both stay low for exactly 200 cycles and then rise.
- R9: A read issued while `read_ok`=0, or a write (`cmd`=3'd3) issued while `write_ok`=0, raises `timing_err` for one cycle. The pulse appears in the cycle after the command. A permitted command raises no pulse.
- R10: A legal load that enables a DLL which is already on does not restart the lockout, so `read_ok` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code: 0 NOP, 1 MRS, 2 read, 3 write, 4 self-refresh entry, 5 self-refresh exit |
| ba | input | 2 | Bank-select bits of the command |
| addr | input | 13 | Row-address bits of the command |
| banks_idle | input | 1 | High when every bank is idle |
| dll_enabled | output | 1 | Effective DLL state |
| drive_weak | output | 1 | Weak output drive selected |
| read_ok | output | 1 | A read is permitted this cycle |
| write_ok | output | 1 | A write is permitted this cycle |
| load_err | output | 1 | Pulse: illegal extended-register load |
| timing_err | output | 1 | Pulse: blocked read or write issued |

## Verification
The assertions assume exactly one command code per cycle. Codes 6 and 7 are assumed to act as no-ops. The assertions also assume that `banks_idle` is a truthful report from the controller, held steady around the clock edge. The bench drives each command for a single cycle on the falling edge and then returns `cmd` to NOP, so no two commands ever share a cycle. It only raises self-refresh exit after a matching entry. Outputs are sampled on falling edges, so every registered result is read one full edge after its command.

// File: rtl/emr_guard_pkg.sv
package emr_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_MRS      = 3'd1,
    CMD_READ     = 3'd2,
    CMD_WRITE    = 3'd3,
    CMD_SREF_IN  = 3'd4,
    CMD_SREF_OUT = 3'd5
  } cmd_e;

  localparam logic [1:0] BA_EXT_SEL = 2'b01;
  localparam int unsigned DLL_BIT   = 0;
  localparam int unsigned DRIVE_BIT = 1;
endpackage

// File: rtl/emr_decode.sv
module emr_decode
  import emr_guard_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [2:0]        cmd,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              in_sref,
  output logic              load_ok,
  output logic              load_bad,
  output logic              dll_off_bit,
  output logic              weak_bit,
  output logic              is_read,
  output logic              is_write,
  output logic              sref_in,
  output logic              sref_out
);
  logic hit_ext;
  logic rsvd_set;

  always_comb begin
    hit_ext     = (cmd == CMD_MRS) && (ba == BA_EXT_SEL);
    rsvd_set    = |addr[ADDR_W-1:2];
    load_bad    = hit_ext && (rsvd_set || !banks_idle || in_sref);
    load_ok     = hit_ext && !load_bad;
    dll_off_bit = addr[DLL_BIT];
    weak_bit    = addr[DRIVE_BIT];
    is_read     = (cmd == CMD_READ);
    is_write    = (cmd == CMD_WRITE);
    sref_in     = (cmd == CMD_SREF_IN);
    sref_out    = (cmd == CMD_SREF_OUT);
  end
endmodule

// File: rtl/emr_state.sv
module emr_state (
  input  logic clk,
  input  logic rst,
  input  logic load_ok,
  input  logic load_bad,
  input  logic dll_off_bit,
  input  logic weak_bit,
  input  logic sref_in,
  input  logic sref_out,
  output logic dll_off,
  output logic drive_weak,
  output logic in_sref,
  output logic dll_on_evt,
  output logic wr_block_evt
);
  logic leave_sref;

  always_comb begin
    leave_sref   = sref_out && in_sref;
    dll_on_evt   = (load_ok && !dll_off_bit && dll_off) || leave_sref;
    wr_block_evt = leave_sref;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dll_off    <= 1'b0;
      drive_weak <= 1'b0;
      in_sref    <= 1'b0;
    end else if (load_ok) begin
      dll_off    <= dll_off_bit;
      drive_weak <= weak_bit;
    end else if (sref_in && !in_sref) begin
      in_sref <= 1'b1;
      dll_off <= 1'b1;
    end else if (leave_sref) begin
      in_sref <= 1'b0;
      dll_off <= 1'b0;
    end
  end

  a_r2_load_drive: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> (drive_weak == $past(weak_bit)) && (dll_off == $past(dll_off_bit)));
  a_r4_bad_keeps: assert property (@(posedge clk) disable iff (rst)
    load_bad |=> $stable(drive_weak) && $stable(dll_off));
  a_r7_sref_dll_off: assert property (@(posedge clk) disable iff (rst)
    in_sref |-> dll_off);
endmodule

// File: rtl/emr_lock_timer.sv
module emr_lock_timer #(
  parameter int LOCK_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic arm_wr,
  output logic busy,
  output logic wr_lock
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LOCK_VAL = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= LOCK_VAL;
      wr_lock <= 1'b0;
    end else if (arm) begin
      cnt     <= LOCK_VAL;
      wr_lock <= arm_wr;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      wr_lock <= 1'b0;
    end
  end

  assign busy = (cnt != '0);

  a_r5_countdown: assert property (@(posedge clk) disable iff (rst)
    (!arm && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r8_armed_busy: assert property (@(posedge clk) disable iff (rst)
    arm |=> busy);
endmodule

// File: rtl/emr_guard.sv
module emr_guard
  import emr_guard_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int LOCK_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmd,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  output logic              dll_enabled,
  output logic              drive_weak,
  output logic              read_ok,
  output logic              write_ok,
  output logic              load_err,
  output logic              timing_err
);
  logic load_ok, load_bad, dll_off_bit, weak_bit;
  logic is_read, is_write, sref_in, sref_out;
  logic dll_off, in_sref, dll_on_evt, wr_block_evt;
  logic busy, wr_lock;

  emr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cmd(cmd), .ba(ba), .addr(addr), .banks_idle(banks_idle), .in_sref(in_sref),
    .load_ok(load_ok), .load_bad(load_bad), .dll_off_bit(dll_off_bit),
    .weak_bit(weak_bit), .is_read(is_read), .is_write(is_write),
    .sref_in(sref_in), .sref_out(sref_out)
  );

  emr_state u_state (
    .clk(clk), .rst(rst), .load_ok(load_ok), .load_bad(load_bad),
    .dll_off_bit(dll_off_bit), .weak_bit(weak_bit), .sref_in(sref_in),
    .sref_out(sref_out), .dll_off(dll_off), .drive_weak(drive_weak),
    .in_sref(in_sref), .dll_on_evt(dll_on_evt), .wr_block_evt(wr_block_evt)
  );

  emr_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .arm(dll_on_evt), .arm_wr(wr_block_evt),
    .busy(busy), .wr_lock(wr_lock)
  );

  always_comb begin
    dll_enabled = !dll_off;
    read_ok     = !dll_off && !busy && !in_sref;
    write_ok    = !in_sref && !(wr_lock && busy);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_err   <= 1'b0;
      timing_err <= 1'b0;
    end else begin
      load_err   <= load_bad;
      timing_err <= (is_read && !read_ok) || (is_write && !write_ok);
    end
  end

  a_r6_no_read_dll_off: assert property (@(posedge clk) disable iff (rst)
    !dll_enabled |-> !read_ok);
  a_r9_read_flagged: assert property (@(posedge clk) disable iff (rst)
    (is_read && !read_ok) |=> timing_err);
  a_r7_sref_blocks: assert property (@(posedge clk) disable iff (rst)
    in_sref |-> (!read_ok && !write_ok));
  a_r4_err_pulse: assert property (@(posedge clk) disable iff (rst)
    load_err |-> $past(load_bad));
endmodule

// File: tb/emr_guard_test.sv
module emr_guard_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd = 3'd0;
  logic [1:0]  ba = 2'b00;
  logic [12:0] addr = '0;
  logic        banks_idle = 1'b1;
  logic dll_enabled, drive_weak, read_ok, write_ok, load_err, timing_err;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  emr_guard uut (
    .clk(clk), .rst(rst), .cmd(cmd), .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .dll_enabled(dll_enabled), .drive_weak(drive_weak), .read_ok(read_ok),
    .write_ok(write_ok), .load_err(load_err), .timing_err(timing_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] c, input logic [1:0] b,
                       input logic [12:0] a, input logic idle);
    @(negedge clk);
    cmd = c; ba = b; addr = a; banks_idle = idle;
    @(negedge clk);
    cmd = 3'd0; ba = 2'b00; addr = '0; banks_idle = 1'b1;
  endtask

  task automatic count_read_low(output int n);
    n = 0;
    while (!read_ok && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int n;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 dll_enabled", dll_enabled, 1);
    chk("R1 drive_weak", drive_weak, 0);
    chk("R1 read_ok", read_ok, 0);
    chk("R1 write_ok", write_ok, 1);
    chk("R1 pulses", load_err + timing_err, 0);
    count_read_low(n);
    chk("R1 lockout length", n, 200);
  endtask

  task automatic t_legal_load;
    int n;
    issue(3'd1, 2'b01, 13'h0002, 1'b1);
    chk("R2 weak drive", drive_weak, 1);
    chk("R2 dll still on", dll_enabled, 1);
    chk("R2 no error", load_err, 0);
    issue(3'd1, 2'b01, 13'h0001, 1'b1);
    chk("R2 dll off", dll_enabled, 0);
    chk("R2 drive normal", drive_weak, 0);
    chk("R6 read_ok low", read_ok, 0);
    issue(3'd2, 2'b00, 13'h0000, 1'b1);
    chk("R6 read with dll off", timing_err, 1);
    issue(3'd1, 2'b01, 13'h0000, 1'b1);
    chk("R5 dll on", dll_enabled, 1);
    chk("R5 write_ok high", write_ok, 1);
    count_read_low(n);
    chk("R5 lockout length", n, 200);
  endtask

  task automatic t_other_bank;
    issue(3'd1, 2'b00, 13'h0003, 1'b1);
    chk("R3 dll unchanged", dll_enabled, 1);
    chk("R3 drive unchanged", drive_weak, 0);
    chk("R3 no error", load_err, 0);
    issue(3'd1, 2'b10, 13'h1FFF, 1'b0);
    chk("R3 no error busy", load_err, 0);
    chk("R3 read_ok kept", read_ok, 1);
  endtask

  task automatic t_illegal;
    issue(3'd1, 2'b01, 13'h0007, 1'b1);
    chk("R4 reserved err", load_err, 1);
    chk("R4 reserved dll kept", dll_enabled, 1);
    @(negedge clk);
    chk("R4 err one cycle", load_err, 0);
    issue(3'd1, 2'b01, 13'h0002, 1'b0);
    chk("R4 busy err", load_err, 1);
    chk("R4 busy drive kept", drive_weak, 0);
    issue(3'd4, 2'b00, 13'h0000, 1'b1);
    issue(3'd1, 2'b01, 13'h0002, 1'b1);
    chk("R4 sref err", load_err, 1);
    chk("R4 sref drive kept", drive_weak, 0);
  endtask

  task automatic t_sref;
    int nr, nw;
    chk("R7 dll off in sref", dll_enabled, 0);
    chk("R7 read blocked", read_ok, 0);
    chk("R7 write blocked", write_ok, 0);
    issue(3'd3, 2'b00, 13'h0000, 1'b1);
    chk("R9 write in sref flagged", timing_err, 1);
    issue(3'd5, 2'b00, 13'h0000, 1'b1);
    chk("R8 dll back on", dll_enabled, 1);
    issue(3'd3, 2'b00, 13'h0000, 1'b1);
    chk("R9 write in lock flagged", timing_err, 1);
    nr = 2; nw = 2;
    while ((!read_ok || !write_ok) && nr < 1000) begin
      if (!read_ok) nr++;
      if (!write_ok) nw++;
      @(negedge clk);
    end
    chk("R8 read lockout", nr, 200);
    chk("R8 write lockout", nw, 200);
  endtask

  task automatic t_permits;
    issue(3'd2, 2'b00, 13'h0000, 1'b1);
    chk("R9 permitted read", timing_err, 0);
    issue(3'd3, 2'b00, 13'h0000, 1'b1);
    chk("R9 permitted write", timing_err, 0);
    issue(3'd1, 2'b01, 13'h0000, 1'b1);
    chk("R10 no restart", read_ok, 1);
    issue(3'd1, 2'b01, 13'h0001, 1'b1);
    issue(3'd1, 2'b01, 13'h0000, 1'b1);
    issue(3'd2, 2'b00, 13'h0000, 1'b1);
    chk("R9 read in lock flagged", timing_err, 1);
    @(negedge clk);
    chk("R9 pulse one cycle", timing_err, 0);
    issue(3'd3, 2'b00, 13'h0000, 1'b1);
    chk("R5 write allowed in read lock", timing_err, 0);
  endtask

  initial begin
    t_reset();
    t_legal_load();
    t_other_bank();
    t_illegal();
    t_sref();
    t_permits();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule